// File: doc/BRIEF.md
# Frame-Synced PCM Serial Port

This block is the serial side of a voice-band sample port. It runs entirely on the master clock. A rising edge on the frame-sync input opens a frame of a fixed number of clocks. In each frame the port shifts one transmit sample out, most significant bit first, and captures one receive sample in. The serial output is enabled only during its time slot and is released to high impedance for the rest of the frame.

A mode input picks the word format for the frame. Companded frames carry 8-bit codes in both directions. Linear frames carry 13-bit two's-complement samples. In linear mode the receive word also carries three trailing volume bits. The transmit sample is taken from a parallel input. The received sample and volume code are handed over in parallel with a one-cycle strobe. A sticky flag records any frame sync that breaks the fixed frame period.

Top module: `pcm_serial_port`

## Requirements
- R1: A frame begins on the clock edge at which `fsync_i` is sampled high after having been sampled low. A sync that arrives exactly `FRAME_LEN` clocks after the previous one starts the next frame with no error.
- R2: Transmit bit k of a frame (k = 0 is the MSB) is on `tx_sd_o` with `tx_oe_o` high during the cycle that follows the k-th edge after the sync edge. `tx_oe_o` is high for exactly 8 cycles in companded frames and 13 cycles in linear frames, and low (high impedance) for the rest of the frame and before the first sync.
- R3: The transmit word is captured from `tx_word_i` on the sync edge. Changes to `tx_word_i` later in the frame do not alter the bits shifted out.
- R4: Receive bit k (k = 0 is the MSB) is sampled from `rx_sd_i` on edge k+1 after the sync edge. A companded frame takes 8 bits and a linear frame takes 16 bits. Later bits in the frame are ignored.
- R5: In a linear frame the first 13 received bits form `rx_word_o` and the last 3 form `rx_vol_o`, most significant volume bit first.
- R6: In a companded frame the 8 received bits appear in `rx_word_o[7:0]` with the upper bits zero, and `rx_vol_o` is 3'b001 (the unity-gain code).
- R7: `rx_valid_o` is high for exactly one cycle, the cycle after the edge that samples the last receive bit. `rx_word_o` and `rx_vol_o` hold their values until the next such pulse.
- R8: `comp_sel_i` high selects companded mode and low selects linear mode. It is sampled only on the sync edge and holds for the whole frame.
- R9: `frame_err_o` is set, and stays set until reset, when a sync arrives at any other distance than `FRAME_LEN` clocks, or when no sync arrives at that distance. An early sync restarts both transfers with correct data.
- R10: While `rst_ni` is low: `tx_oe_o`, `tx_sd_o`, `rx_valid_o` and `frame_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync |
| comp_sel_i | input | 1 | 1 = 8-bit companded, 0 = 13-bit linear |
| tx_word_i | input | LIN_W | Transmit sample; low CMP_W bits used in companded mode |
| rx_sd_i | input | 1 | Serial receive data |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit drive enable; low means high impedance |
| rx_word_o | output | LIN_W | Received sample |
| rx_vol_o | output | 3 | Received volume code |
| rx_valid_o | output | 1 | One-cycle strobe for a new received sample |
| frame_err_o | output | 1 | Sticky frame-period error |

## Verification
The bench builds the port with `FRAME_LEN` = 32 and keeps the default 8-bit and 13-bit word widths. The short frame lets the bench run every 8-bit code through a companded frame in both directions. It also runs a linear sweep that visits all eight volume codes. A frame of this length still leaves idle slots after the 16-bit receive word, so the bench can check the disabled output, the ignored trailing receive bits and the exact sync spacing. Both early-sync and missing-sync errors are reached in a few hundred cycles each.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned VOL_W = 3;
  localparam logic [VOL_W-1:0] VOL_UNITY = 3'b001;

  typedef enum logic {
    MODE_LIN = 1'b0,
    MODE_CMP = 1'b1
  } pcm_mode_e;
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int unsigned FRAME_LEN = 256,
  localparam int unsigned SLOT_W = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  output logic              sync_det_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_err_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

  logic              fsync_q;
  logic              in_frame_q;
  logic [SLOT_W-1:0] slot_q;
  logic              err_q;
  logic              at_last;

  assign sync_det_o = fsync_i & ~fsync_q;
  assign at_last    = (slot_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_q    <= 1'b0;
      in_frame_q <= 1'b0;
      slot_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      fsync_q <= fsync_i;
      if (sync_det_o) begin
        slot_q     <= '0;
        in_frame_q <= 1'b1;
        if (in_frame_q && !at_last) err_q <= 1'b1;
      end else if (in_frame_q) begin
        slot_q <= at_last ? '0 : slot_q + 1'b1;
        if (at_last) err_q <= 1'b1;  // period elapsed with no sync
      end
    end
  end

  assign slot_o      = slot_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int unsigned LIN_W = 13,
  parameter int unsigned CMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             cmp_i,
  input  logic [LIN_W-1:0] word_i,
  output logic             sd_o,
  output logic             oe_o
);
  localparam int unsigned CNT_W = $clog2(LIN_W + 1);
  localparam int unsigned PAD_W = LIN_W - CMP_W;

  logic [LIN_W-1:0] sh_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      // companded code is left-aligned so the MSB tap is shared
      sh_q   <= cmp_i ? {word_i[CMP_W-1:0], {PAD_W{1'b0}}} : word_i;
      left_q <= cmp_i ? CNT_W'(CMP_W) : CNT_W'(LIN_W);
    end else if (left_q != '0) begin
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign oe_o = (left_q != '0);
  assign sd_o = oe_o & sh_q[LIN_W-1];
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer
  import pcm_port_pkg::*;
#(
  parameter int unsigned LIN_W = 13,
  parameter int unsigned CMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             cmp_i,
  input  logic             sd_i,
  output logic [LIN_W-1:0] word_o,
  output logic [VOL_W-1:0] vol_o,
  output logic             valid_o
);
  localparam int unsigned RX_W  = LIN_W + VOL_W;
  localparam int unsigned CNT_W = $clog2(RX_W + 1);
  localparam int unsigned PAD_W = LIN_W - CMP_W;

  logic [RX_W-1:0]  sh_q;
  logic [CNT_W-1:0] left_q;
  logic             cmp_q;
  logic [LIN_W-1:0] word_q;
  logic [VOL_W-1:0] vol_q;
  logic             valid_q;
  logic [RX_W-1:0]  full;

  assign full = {sh_q[RX_W-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      cmp_q   <= 1'b0;
      word_q  <= '0;
      vol_q   <= VOL_UNITY;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (load_i) begin
        left_q <= cmp_i ? CNT_W'(CMP_W) : CNT_W'(RX_W);
        cmp_q  <= cmp_i;
      end else if (left_q != '0) begin
        sh_q   <= full;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          valid_q <= 1'b1;
          if (cmp_q) begin
            word_q <= {{PAD_W{1'b0}}, full[CMP_W-1:0]};
            vol_q  <= VOL_UNITY;
          end else begin
            word_q <= full[RX_W-1:VOL_W];
            vol_q  <= full[VOL_W-1:0];
          end
        end
      end
    end
  end

  assign word_o  = word_q;
  assign vol_o   = vol_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned LIN_W     = 13,
  parameter int unsigned CMP_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             comp_sel_i,
  input  logic [LIN_W-1:0] tx_word_i,
  input  logic             rx_sd_i,
  output logic             tx_sd_o,
  output logic             tx_oe_o,
  output logic [LIN_W-1:0] rx_word_o,
  output logic [VOL_W-1:0] rx_vol_o,
  output logic             rx_valid_o,
  output logic             frame_err_o
);
  localparam int unsigned SLOT_W = $clog2(FRAME_LEN);

  logic              sync_det;
  logic [SLOT_W-1:0] slot;

  pcm_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .sync_det_o (sync_det),
    .slot_o     (slot),
    .frame_err_o(frame_err_o)
  );

  pcm_tx_serializer #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sync_det),
    .cmp_i  (comp_sel_i == MODE_CMP),
    .word_i (tx_word_i),
    .sd_o   (tx_sd_o),
    .oe_o   (tx_oe_o)
  );

  pcm_rx_deserializer #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sync_det),
    .cmp_i  (comp_sel_i == MODE_CMP),
    .sd_i   (rx_sd_i),
    .word_o (rx_word_o),
    .vol_o  (rx_vol_o),
    .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned SLOT_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_det,
  input logic [SLOT_W-1:0] slot,
  input logic              tx_oe_o,
  input logic              rx_valid_o,
  input logic              frame_err_o
);
  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

  assert_oe_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe_o) |-> $past(sync_det));

  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> ($past(sync_det) || ($past(slot) == SLOT_W'(FRAME_LEN - 1))));
endmodule

bind pcm_serial_port pcm_serial_port_chk #(.FRAME_LEN(FRAME_LEN), .SLOT_W(SLOT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_det   (sync_det),
  .slot       (slot),
  .tx_oe_o    (tx_oe_o),
  .rx_valid_o (rx_valid_o),
  .frame_err_o(frame_err_o)
);

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
  localparam int FL = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fsync = 1'b0;
  logic        comp_sel = 1'b0;
  logic [12:0] tx_word = '0;
  logic        rx_sd = 1'b0;
  logic        tx_sd_o, tx_oe_o, rx_valid_o, frame_err_o;
  logic [12:0] rx_word_o;
  logic [2:0]  rx_vol_o;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_err = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcm_serial_port #(.FRAME_LEN(FL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fsync_i(fsync), .comp_sel_i(comp_sel),
    .tx_word_i(tx_word), .rx_sd_i(rx_sd), .tx_sd_o(tx_sd_o), .tx_oe_o(tx_oe_o),
    .rx_word_o(rx_word_o), .rx_vol_o(rx_vol_o), .rx_valid_o(rx_valid_o),
    .frame_err_o(frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    fsync   = 1'b0;
    exp_err = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_oe_o == 1'b0, "R10 oe", int'(tx_oe_o), 0);
    chk(tx_sd_o == 1'b0, "R10 sd", int'(tx_sd_o), 0);
    chk(rx_valid_o == 1'b0, "R10 valid", int'(rx_valid_o), 0);
    chk(frame_err_o == 1'b0, "R10 err", int'(frame_err_o), 0);
    rst_ni = 1'b1;
  endtask

  // One frame of len clocks; k counts negedges after the sync edge.
  task automatic run_frame(input bit cmp, input logic [12:0] txw,
                           input logic [15:0] rxv, input int len);
    int  n = cmp ? 8 : 13;
    int  m = cmp ? 8 : 16;
    bit  exp_oe, exp_bit, exp_v;
    logic [12:0] exp_w;
    logic [2:0]  exp_vol;
    @(negedge clk);
    chk(tx_oe_o == 1'b0, "R2 idle before sync", int'(tx_oe_o), 0);
    fsync    = 1'b1;
    comp_sel = cmp;
    tx_word  = txw;
    for (int k = 0; k < len - 1; k++) begin
      @(negedge clk);
      if (k == 0) begin
        fsync    = 1'b0;
        comp_sel = ~cmp;   // R8: mode is latched at sync
        tx_word  = ~txw;   // R3: word is latched at sync
        chk(frame_err_o == exp_err, "R1/R9 err flag", int'(frame_err_o), int'(exp_err));
      end
      exp_oe = (k < n);
      chk(tx_oe_o == exp_oe, "R2 oe slot", int'(tx_oe_o), int'(exp_oe));
      if (exp_oe) begin
        exp_bit = cmp ? txw[7-k] : txw[12-k];
        chk(tx_sd_o == exp_bit, "R2/R3 tx bit", int'(tx_sd_o), int'(exp_bit));
      end
      rx_sd = (k < m) ? rxv[m-1-k] : 1'b1;  // R4: trailing bits ignored
      exp_v = (k == m);
      chk(rx_valid_o == exp_v, "R7 valid timing", int'(rx_valid_o), int'(exp_v));
      if (exp_v) begin
        if (cmp) begin
          exp_w   = {5'b0, rxv[7:0]};
          exp_vol = 3'b001;
          chk(rx_word_o == exp_w, "R6/R4 cmp word", int'(rx_word_o), int'(exp_w));
          chk(rx_vol_o == exp_vol, "R6 unity vol", int'(rx_vol_o), int'(exp_vol));
        end else begin
          exp_w   = rxv[15:3];
          exp_vol = rxv[2:0];
          chk(rx_word_o == exp_w, "R5/R4 lin word", int'(rx_word_o), int'(exp_w));
          chk(rx_vol_o == exp_vol, "R5 lin vol", int'(rx_vol_o), int'(exp_vol));
        end
      end
      if (k == m + 1) begin
        exp_w = cmp ? {5'b0, rxv[7:0]} : rxv[15:3];
        chk(rx_word_o == exp_w, "R7 word held", int'(rx_word_o), int'(exp_w));
      end
    end
  endtask

  initial begin
    logic [12:0] w;
    logic [15:0] r;
    do_reset();
    // companded sweep over every code
    for (int i = 0; i < 256; i++) begin
      w = {5'(i ^ 5'h15), 8'(i)};
      r = {8'h00, 8'(255 - i)};
      run_frame(1'b1, w, r, FL);
    end
    // linear sweep, all volume codes
    for (int i = 0; i < 128; i++) begin
      w = 13'((i * 617 + 3) & 13'h1fff);
      r = {13'((i * 1237 + 5) & 13'h1fff), 3'(i)};
      run_frame(1'b0, w, r, FL);
    end
    run_frame(1'b0, 13'h1000, 16'h8001, FL);
    run_frame(1'b0, 13'h0001, 16'h7ffe, FL);
    // early sync: short frame, then restart with correct data (R9)
    run_frame(1'b1, 13'h00a5, 16'h005a, 10);
    exp_err = 1'b1;
    run_frame(1'b0, 13'h0b3c, 16'hc3a5, FL);
    run_frame(1'b1, 13'h0077, 16'h0088, FL);
    // missing sync (R9)
    do_reset();
    run_frame(1'b0, 13'h1234, 16'h4321, FL);
    repeat (FL + 2) @(negedge clk);
    chk(frame_err_o == 1'b1, "R9 missing sync", int'(frame_err_o), 1);
    chk(tx_oe_o == 1'b0, "R2 oe off without sync", int'(tx_oe_o), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule